// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

The router collects level-sensitive interrupt lines from up to 64 devices into one raw request register. The register is sampled on every clock, so each bit follows the present level of its line. A separate mask register is kept for each of up to four CPUs. Each CPU has one hard-interrupt output, which is high whenever its mask and the raw request share a set bit. The per-CPU request word is never stored. It is formed from the mask and the raw request whenever it is needed. The output of one legacy cascaded interrupt controller enters the raw request at a fixed bit position.

Software reaches the block through a 32-bit register port. Each 64-bit register is accessed as two words, and one shared word latch pairs the two halves. A write with address bit 2 clear only loads the latch. The matching write with bit 2 set commits the whole 64-bit value. A read with bit 2 clear returns the low word and parks the high word in the latch. The read with bit 2 set returns the parked word. An access to an offset that holds no register raises an error strobe and reads back as all ones.

Top module: `irq_router`

## Requirements
- R1: One clock edge after a device line changes level, its bit in the raw request register holds the new level. Bits are set and cleared alike.
- R2: Raw request bit 55 holds the OR of the legacy controller input and device line 55.
- R3: A CPU's output `cpu_irq[c]` is registered. After every clock edge it equals the OR-reduction of (mask c AND raw request), using the values that edge stored. A mask commit or a line change therefore shows on the output in the same edge that stores it.
- R4: A write with address bit 2 clear changes no mask and no output. It only loads the shared word latch with the write data.
- R5: A write with address bit 2 set to a mask offset stores {write data, latch} into that mask, with the write data as bits 63:32.
- R6: A read with address bit 2 clear returns bits 31:0 of the addressed register and loads bits 63:32 into the latch. A read with bit 2 set returns the latch, whatever the latch was last loaded by (a read or a write).
- R7: A read of a CPU's request offset returns (mask AND raw request) at the time of the read. A read of the raw request offset returns the raw request.
- R8: Writes to request offsets and to the raw request offset change no register and raise no error.
- R9: An error is raised in the same cycle, and `csr_rdata` is all ones, for two cases: a read with address bit 2 clear, or a write with bit 2 set, to an unassigned offset. Such a read leaves the latch unchanged.
- R10: Reset clears the raw request, every mask, the latch and every `cpu_irq` output.
- R11: Register offsets, with bit 2 clear, are as follows. Masks for CPU0 to CPU3 sit at 0x200, 0x240, 0x600 and 0x640. Requests for CPU0 to CPU3 sit at 0x280, 0x2C0, 0x680 and 0x6C0. The raw request sits at 0x300. Every other offset is unassigned. A mask drives only its own CPU's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | NUM_DEV | Level interrupt lines, one per device |
| legacy_irq | input | 1 | Output of the cascaded legacy controller |
| csr_valid | input | 1 | Register access in this cycle |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 10 | Byte offset bits 11:2; bit 2 selects the high word |
| csr_wdata | input | CSR_W | Write data |
| csr_rdata | output | CSR_W | Read data, valid in the access cycle |
| csr_err | output | 1 | Unassigned-offset strobe, same cycle |
| cpu_irq | output | NUM_CPU | Registered hard-interrupt request per CPU |

## Verification
The bench builds the router with its defaults: 64 device lines, four CPUs, the legacy input folded in, and a 32-bit port. This makes every mask and request offset reachable, including the upper pair at 0x600 and above, and it exercises bit 63 and the folded bit 55. With a full 64-bit mask, both halves of each word carry live bits. Any error in pairing the halves, such as a swap or a premature commit, therefore changes an output.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int OFS_W = 12;

   localparam logic [OFS_W-1:0] MASK_BASE_A = 12'h200;
   localparam logic [OFS_W-1:0] MASK_BASE_B = 12'h600;
   localparam logic [OFS_W-1:0] REQ_SHIFT   = 12'h080;
   localparam logic [OFS_W-1:0] RAW_OFS     = 12'h300;
   localparam logic [OFS_W-1:0] CPU_STRIDE  = 12'h040;

   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_MASK = 2'd1,
      KIND_REQ  = 2'd2,
      KIND_RAW  = 2'd3
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [1:0] cpu;
   } reg_sel_t;

   // Offset of a 64-bit register (bits 2:0 zero) to register kind and CPU
   function automatic reg_sel_t decode_ofs(logic [OFS_W-1:0] ofs);
      reg_sel_t         sel;
      logic [OFS_W-1:0] base;
      sel.kind = KIND_NONE;
      sel.cpu  = 2'd0;
      if (ofs == RAW_OFS) sel.kind = KIND_RAW;
      for (int c = 0; c < 4; c++) begin
         base = ((c < 2) ? MASK_BASE_A : MASK_BASE_B) + OFS_W'(c % 2) * CPU_STRIDE;
         if (ofs == base) begin
            sel.kind = KIND_MASK;
            sel.cpu  = 2'(c);
         end
         if (ofs == base + REQ_SHIFT) begin
            sel.kind = KIND_REQ;
            sel.cpu  = 2'(c);
         end
      end
      return sel;
   endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
   parameter int NUM_DEV    = 64,
   parameter int LEGACY_POS = 55,
   parameter bit LEGACY_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] dev_irq,
   input  logic               legacy_irq,
   output logic [NUM_DEV-1:0] raw_next,
   output logic [NUM_DEV-1:0] raw_q
);

   generate
      if (LEGACY_EN) begin : g_fold
         assign raw_next = dev_irq | (NUM_DEV'(legacy_irq) << LEGACY_POS);
      end else begin : g_plain
         assign raw_next = dev_irq;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= raw_next;
   end

endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
   parameter int NUM_DEV = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [NUM_DEV-1:0] wr_val,
   input  logic [NUM_DEV-1:0] raw_next,
   output logic [NUM_DEV-1:0] mask_q,
   output logic               irq_q
);

   logic [NUM_DEV-1:0] mask_d;

   assign mask_d = wr_en ? wr_val : mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         mask_q <= mask_d;
         irq_q  <= |(mask_d & raw_next);
      end
   end

endmodule

// File: rtl/irq_csr_latch.sv
module irq_csr_latch #(
   parameter int CSR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic             acc_hi,
   input  logic             acc_hit,
   input  logic [CSR_W-1:0] wdata,
   input  logic [CSR_W-1:0] rd_upper,
   output logic [CSR_W-1:0] latch_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (acc_valid && !acc_hi) begin
         if (acc_write)    latch_q <= wdata;
         else if (acc_hit) latch_q <= rd_upper;
      end
   end

endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int NUM_DEV    = 64,
   parameter int NUM_CPU    = 4,
   parameter int LEGACY_POS = 55,
   parameter bit LEGACY_EN  = 1'b1,
   parameter int CSR_W      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] dev_irq,
   input  logic               legacy_irq,
   input  logic               csr_valid,
   input  logic               csr_write,
   input  logic [OFS_W-1:2]   csr_addr,
   input  logic [CSR_W-1:0]   csr_wdata,
   output logic [CSR_W-1:0]   csr_rdata,
   output logic               csr_err,
   output logic [NUM_CPU-1:0] cpu_irq
);

   localparam int REG_W = 2 * CSR_W;

   if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
      $error("irq_router: NUM_CPU must lie in 1..4");
   end
   if (NUM_DEV < 1 || NUM_DEV > REG_W) begin : g_bad_dev
      $error("irq_router: NUM_DEV must lie in 1..2*CSR_W");
   end
   if (LEGACY_EN && LEGACY_POS >= NUM_DEV) begin : g_bad_pos
      $error("irq_router: LEGACY_POS outside the device range");
   end

   logic [NUM_DEV-1:0]         raw_next, raw_q;
   logic [NUM_DEV-1:0]         mask_q [NUM_CPU];
   logic [NUM_CPU*NUM_DEV-1:0] mask_flat;
   logic [NUM_CPU-1:0]         wr_en;
   logic [NUM_DEV-1:0]         wr_val;
   logic [CSR_W-1:0]           latch_q;
   logic [REG_W-1:0]           rd_full;
   logic [NUM_DEV-1:0]         sel_mask;
   reg_sel_t                   sel;
   logic                       hi, hit;

   assign hi  = csr_addr[2];
   assign sel = decode_ofs({csr_addr[OFS_W-1:3], 3'b000});
   assign hit = (sel.kind != KIND_NONE) && (int'(sel.cpu) < NUM_CPU);

   irq_raw_capture #(
      .NUM_DEV(NUM_DEV), .LEGACY_POS(LEGACY_POS), .LEGACY_EN(LEGACY_EN)
   ) u_raw (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .legacy_irq(legacy_irq),
      .raw_next(raw_next), .raw_q(raw_q)
   );

   assign wr_val = NUM_DEV'({csr_wdata, latch_q});

   generate
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
         assign wr_en[c] = csr_valid && csr_write && hi &&
                           (sel.kind == KIND_MASK) && (sel.cpu == 2'(c));
         irq_cpu_lane #(.NUM_DEV(NUM_DEV)) u_lane (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en[c]), .wr_val(wr_val),
            .raw_next(raw_next), .mask_q(mask_q[c]), .irq_q(cpu_irq[c])
         );
         assign mask_flat[c*NUM_DEV +: NUM_DEV] = mask_q[c];
      end
   endgenerate

   always_comb begin
      sel_mask = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (sel.cpu == 2'(c)) sel_mask = mask_q[c];
      end
      case (sel.kind)
         KIND_MASK: rd_full = REG_W'(sel_mask);
         KIND_REQ:  rd_full = REG_W'(sel_mask & raw_q);
         KIND_RAW:  rd_full = REG_W'(raw_q);
         default:   rd_full = '0;
      endcase
   end

   irq_csr_latch #(.CSR_W(CSR_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .acc_valid(csr_valid), .acc_write(csr_write),
      .acc_hi(hi), .acc_hit(hit), .wdata(csr_wdata),
      .rd_upper(rd_full[REG_W-1:CSR_W]), .latch_q(latch_q)
   );

   assign csr_err = csr_valid && !hit && (csr_write == hi);

   always_comb begin
      csr_rdata = '0;
      if (csr_err)                      csr_rdata = '1;
      else if (csr_valid && !csr_write) csr_rdata = hi ? latch_q : rd_full[CSR_W-1:0];
   end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int NUM_DEV = 64,
   parameter int NUM_CPU = 4,
   parameter int CSR_W   = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_DEV-1:0]         dev_irq,
   input logic                       csr_valid,
   input logic                       csr_write,
   input logic                       addr_hi,
   input logic [CSR_W-1:0]           csr_rdata,
   input logic                       csr_err,
   input logic [NUM_CPU-1:0]         cpu_irq,
   input logic [NUM_DEV-1:0]         raw_q,
   input logic [NUM_CPU*NUM_DEV-1:0] mask_flat,
   input logic [CSR_W-1:0]           latch_q
);

   generate
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
         // R3
         irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] == |(mask_flat[c*NUM_DEV +: NUM_DEV] & raw_q));
      end
   endgenerate

   // R1
   raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> raw_q[0] == $past(dev_irq[0]));

   // R4
   low_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && csr_write && !addr_hi) |=> $stable(mask_flat));

   // R6
   high_read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && !csr_write && addr_hi) |-> csr_rdata == latch_q);

   // R9
   err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_err |-> csr_rdata == {CSR_W{1'b1}});

endmodule

bind irq_router irq_router_chk #(
   .NUM_DEV(NUM_DEV), .NUM_CPU(NUM_CPU), .CSR_W(CSR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .csr_valid(csr_valid),
   .csr_write(csr_write), .addr_hi(csr_addr[2]), .csr_rdata(csr_rdata),
   .csr_err(csr_err), .cpu_irq(cpu_irq), .raw_q(raw_q),
   .mask_flat(mask_flat), .latch_q(latch_q)
);

// File: tb/irq_router_test.sv
`timescale 1ns/100ps
module irq_router_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] dev;
   logic        leg;
   logic        v, w;
   logic [11:0] a;
   logic [31:0] wd;
   logic [31:0] rd;
   logic        er;
   logic [3:0]  irq;

   always #2.5 clk = ~clk;

   irq_router uut (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev), .legacy_irq(leg),
      .csr_valid(v), .csr_write(w), .csr_addr(a[11:2]), .csr_wdata(wd),
      .csr_rdata(rd), .csr_err(er), .cpu_irq(irq)
   );

   int errors = 0;
   int checks = 0;

   logic [63:0] m_mask [4];
   logic [63:0] m_raw;
   logic [31:0] m_latch;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int mask_idx(logic [11:0] adr);
      case ({adr[11:3], 3'b000})
         12'h200: return 0;
         12'h240: return 1;
         12'h600: return 2;
         12'h640: return 3;
         default: return -1;
      endcase
   endfunction

   function automatic bit model_read(logic [11:0] adr, output logic [63:0] val, output string tag);
      tag = "R7";
      val = '0;
      case ({adr[11:3], 3'b000})
         12'h200: begin val = m_mask[0]; tag = "R6"; end
         12'h240: begin val = m_mask[1]; tag = "R6"; end
         12'h600: begin val = m_mask[2]; tag = "R6"; end
         12'h640: begin val = m_mask[3]; tag = "R6"; end
         12'h280: val = m_mask[0] & m_raw;
         12'h2C0: val = m_mask[1] & m_raw;
         12'h680: val = m_mask[2] & m_raw;
         12'h6C0: val = m_mask[3] & m_raw;
         12'h300: val = m_raw;
         default: begin tag = "R9"; return 1'b0; end
      endcase
      return 1'b1;
   endfunction

   task automatic step(bit vv, bit ww, logic [11:0] aa, logic [31:0] dd, output logic [31:0] got);
      logic [63:0] val;
      string       tag;
      bit          hit;
      logic [31:0] exp_rd;
      bit          exp_er;
      logic [3:0]  exp_irq;
      @(negedge clk);
      v = vv; w = ww; a = aa; wd = dd;
      #2;
      hit = model_read(aa, val, tag);
      if (vv) begin
         exp_er = !hit && (ww == aa[2]);
         if (exp_er)        exp_rd = '1;
         else if (ww)       exp_rd = '0;
         else if (aa[2])    exp_rd = m_latch;
         else               exp_rd = val[31:0];
         if (!ww && aa[2]) tag = "R6";
         if (exp_er) tag = "R9";
         check(tag, 64'(rd), 64'(exp_rd));
         check(tag, 64'(er), 64'(exp_er));
      end
      got = rd;
      @(posedge clk);
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) m_mask[k] = '0;
         m_raw = '0;
         m_latch = '0;
      end else begin
         if (vv && ww && !aa[2]) m_latch = dd;
         if (vv && ww && aa[2] && mask_idx(aa) >= 0) m_mask[mask_idx(aa)] = {dd, m_latch};
         if (vv && !ww && !aa[2] && hit) m_latch = val[63:32];
         m_raw = dev | (64'(leg) << 55);
      end
      #1;
      for (int k = 0; k < 4; k++) exp_irq[k] = |(m_mask[k] & m_raw);
      check("R3", 64'(irq), 64'(exp_irq));
      v = 1'b0;
   endtask

   task automatic idle(int n);
      logic [31:0] g;
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 12'h000, 32'h0, g);
   endtask

   task automatic wr64(logic [11:0] adr, logic [63:0] data);
      logic [31:0] g;
      step(1'b1, 1'b1, adr, data[31:0], g);
      step(1'b1, 1'b1, adr | 12'h004, data[63:32], g);
   endtask

   task automatic rd64(logic [11:0] adr, output logic [63:0] data);
      logic [31:0] lo, hi;
      step(1'b1, 1'b0, adr, 32'h0, lo);
      step(1'b1, 1'b0, adr | 12'h004, 32'h0, hi);
      data = {hi, lo};
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] r;
      logic [31:0] g;
      logic [11:0] pool [12];
      pool = '{12'h200, 12'h240, 12'h600, 12'h640, 12'h280, 12'h2C0,
               12'h680, 12'h6C0, 12'h300, 12'h208, 12'h000, 12'h7C0};
      v = 0; w = 0; a = '0; wd = '0;
      rst_n = 1'b0; dev = '1; leg = 1'b1;
      idle(3);
      check("R10", 64'(irq), 64'h0);
      dev = '0; leg = 1'b0; rst_n = 1'b1;
      // R10: latch cleared, high read first returns zero
      step(1'b1, 1'b0, 12'h204, 32'h0, g);
      check("R10", 64'(g), 64'h0);
      rd64(12'h640, r); check("R10", r, 64'h0);
      rd64(12'h300, r); check("R10", r, 64'h0);

      // R1: line level sets and clears its raw bit
      dev = 64'h8000_0000_0000_0001;
      idle(1);
      rd64(12'h300, r); check("R1", r, 64'h8000_0000_0000_0001);
      dev = 64'h0000_0000_0000_0001;
      idle(1);
      rd64(12'h300, r); check("R1", r, 64'h1);

      // R4: low half alone commits nothing
      step(1'b1, 1'b1, 12'h200, 32'h0000_0001, g);
      check("R4", 64'(irq[0]), 64'h0);
      rd64(12'h200, r); check("R4", r, 64'h0);
      // R5: high half commits {data, latch}
      step(1'b1, 1'b1, 12'h200, 32'h0000_0001, g);
      step(1'b1, 1'b1, 12'h204, 32'hA5A5_0000, g);
      check("R5", 64'(irq[0]), 64'h1);
      rd64(12'h200, r); check("R5", r, 64'hA5A5_0000_0000_0001);
      rd64(12'h280, r); check("R7", r, 64'h1);

      // R2: legacy input folds onto bit 55
      wr64(12'h240, 64'h0080_0000_0000_0000);
      check("R2", 64'(irq[1]), 64'h0);
      leg = 1'b1;
      idle(1);
      check("R2", 64'(irq[1]), 64'h1);
      rd64(12'h300, r); check("R2", r, 64'h0080_0000_0000_0001);
      leg = 1'b0;
      idle(1);
      check("R2", 64'(irq[1]), 64'h0);

      // R8: writes to request and raw offsets are ignored
      wr64(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
      wr64(12'h2C0, 64'h1234_5678_9ABC_DEF0);
      rd64(12'h300, r); check("R8", r, 64'h1);
      rd64(12'h240, r); check("R8", r, 64'h0080_0000_0000_0000);

      // R9: unassigned read gives ones and keeps the latch
      step(1'b1, 1'b0, 12'h200, 32'h0, g);
      step(1'b1, 1'b0, 12'h208, 32'h0, g);
      check("R9", 64'(g), 64'hFFFF_FFFF);
      step(1'b1, 1'b0, 12'h20C, 32'h0, g);
      check("R9", 64'(g), 64'hA5A5_0000);
      step(1'b1, 1'b1, 12'h7C4, 32'h0, g);
      check("R9", 64'(g), 64'hFFFF_FFFF);

      // R6: write-loaded latch is what a high read returns
      step(1'b1, 1'b1, 12'h000, 32'hCAFE_F00D, g);
      step(1'b1, 1'b0, 12'h684, 32'h0, g);
      check("R6", 64'(g), 64'hCAFE_F00D);

      // R11: upper-bank masks drive only their own CPU
      dev = 64'h0000_0010_0000_0000;
      wr64(12'h640, 64'h0000_0010_0000_0000);
      check("R11", 64'(irq), 64'h8);
      wr64(12'h600, 64'h0000_0030_0000_0000);
      check("R11", 64'(irq), 64'hC);
      rd64(12'h6C0, r); check("R11", r, 64'h0000_0010_0000_0000);
      rd64(12'h680, r); check("R11", r, 64'h0000_0010_0000_0000);
      dev = '0;
      idle(1);
      check("R1", 64'(irq), 64'h0);

      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         logic [11:0] ad;
         if ($urandom % 4 == 0) dev = {$urandom, $urandom} & {$urandom, $urandom};
         leg = ($urandom % 5 == 0);
         ad = pool[$urandom % 12] | (($urandom % 2 == 1) ? 12'h004 : 12'h000);
         step(($urandom % 4) != 0, $urandom % 2 == 1, ad, $urandom, g);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule